// File: doc/BRIEF.md
# Block-Write Configuration Register Slave

This block is a two-wire serial slave at standard-mode rates (up to 100 kbit/s) that holds six 8-bit configuration registers for a clock-generation core. The bus lines are sampled with the system clock, which must run much faster than SCL. The block pulls SDA low through an open-drain enable and never stretches SCL. A host writes the registers in one sweep. It sends the write address, then two header bytes that the block acknowledges and then throws away, then data bytes. The first data byte always lands in register 0 and each following byte goes to the next register up. The host may stop after any complete byte.

A read sends the number of registers as a count byte, then registers 0 to 5 in turn, most significant bit first. The stored registers drive the frequency-select and clock-enable logic directly through a flat output bus. Register 4 has four bit positions that always read back the inverted live levels of the hardware strap inputs. Those positions still store whatever was written to them, and the stored value appears on the output bus.

Top module: `cfg_i2c_blkslave`

## Requirements
- R1: The block acknowledges only the address byte 0xD2 (write) and 0xD3 (read). After any other address byte it leaves SDA released and ignores the bus until the next start, so the registers do not change.
- R2: In a write, the two bytes after the address are acknowledged and never stored.
- R3: Data bytes are stored in order from register 0 upward. A stop after any complete byte ends loading and leaves the higher registers unchanged. The register bus changes only when a data byte is committed.
- R4: Every byte of an addressed write is acknowledged. Data bytes past register 5 are also acknowledged, but they are discarded.
- R5: A read first returns the count byte 0x06, then registers 0 to 5, MSB first. Each acknowledge from the master moves to the next byte.
- R6: After reset, register 0 holds 0x00 and registers 1 to 5 hold 0xFF. Register k drives regs_o[8k+7:8k].
- R7: On read-back, register 4 bits [7:4] return ~strap_i[3:0] at the time of the read. All other bits return the stored value. regs_o always shows the stored value, including bits [7:4] of register 4.
- R8: A NACK from the master ends the read. The block releases SDA, and the next start is handled normally. Bytes requested after register 5 read as 0xFF.
- R9: The SDA drive changes only while SCL is low, or when a start or stop releases it. A stop always releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain) |
| strap_i | input | 4 | Live strap levels for read-back |
| regs_o | output | 48 | Stored registers, register k at bits [8k+7:8k] |

## Verification
The assertions assume that SDA changes only while SCL is low, except at start and stop conditions. They also assume that each SCL phase lasts several system clocks longer than the synchronizer delay, so that an edge seen by the block still holds when the drive changes. The bench moves the bus in quarter-bit steps of ten system clocks. It changes data only in the middle of the SCL low phase and samples in the middle of the high phase. It makes a start or stop only while SCL is high with SDA held steady on either side.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK
  } phase_e;
endpackage

// File: rtl/cfg_i2c_line_mon.sv
module cfg_i2c_line_mon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_STAGES-1];
      sda_d  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges while SCL is high mark bus conditions
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/cfg_i2c_regfile.sv
module cfg_i2c_regfile #(
  parameter int unsigned NUM_REGS  = 6,
  parameter int unsigned STRAP_W   = 4,
  parameter int unsigned STRAP_REG = 4,
  parameter int unsigned STRAP_LSB = 4,
  parameter logic [NUM_REGS*8-1:0] RST_VAL = '0,
  localparam int unsigned IDX_W = $clog2(NUM_REGS),
  localparam int unsigned SEL_W = $clog2(NUM_REGS + 2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [SEL_W-1:0]      rd_sel_i,
  input  logic [STRAP_W-1:0]    strap_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] reg_q  [NUM_REGS];
  logic [7:0] view_w [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        reg_q[g] <= RST_VAL[g*8 +: 8];
      else if (wr_en_i && wr_idx_i == IDX_W'(g))
        reg_q[g] <= wr_data_i;
    end

    assign regs_o[g*8 +: 8] = reg_q[g];

    if (g == STRAP_REG) begin : g_strap
      always_comb begin
        view_w[g] = reg_q[g];
        view_w[g][STRAP_LSB +: STRAP_W] = ~strap_i;
      end
    end else begin : g_plain
      assign view_w[g] = reg_q[g];
    end
  end

  // sel 0: count byte, 1..N: registers, beyond: idle pattern
  always_comb begin
    rd_data_o = 8'hFF;
    if (rd_sel_i == '0) rd_data_o = 8'(NUM_REGS);
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_sel_i == SEL_W'(k + 1)) rd_data_o = view_w[k];
    end
  end
endmodule

// File: rtl/cfg_i2c_proto.sv
module cfg_i2c_proto
  import cfg_i2c_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 6,
  parameter logic [6:0]  SLAVE_ADDR = 7'h69,
  parameter int unsigned HDR_BYTES  = 2,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned SEL_W    = $clog2(NUM_REGS + 2),
  localparam int unsigned SEL_MAX  = NUM_REGS + 1,
  localparam int unsigned WCNT_MAX = HDR_BYTES + NUM_REGS,
  localparam int unsigned WCNT_W   = $clog2(WCNT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_bit_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic [SEL_W-1:0] rd_sel_o
);
  phase_e            phase_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        sh_q;
  logic              is_addr_q, rw_q, nack_q, oe_q;
  logic [WCNT_W-1:0] wcnt_q;
  logic [SEL_W-1:0]  sel_q;
  logic              wr_en_q;
  logic [IDX_W-1:0]  wr_idx_q;
  logic [7:0]        wr_data_q;
  logic              data_slot;

  assign data_slot = (wcnt_q >= WCNT_W'(HDR_BYTES)) && (wcnt_q < WCNT_W'(WCNT_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      is_addr_q <= 1'b0;
      rw_q      <= 1'b0;
      nack_q    <= 1'b0;
      oe_q      <= 1'b0;
      wcnt_q    <= '0;
      sel_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (stop_i) begin
        phase_q <= PH_IDLE;
        oe_q    <= 1'b0;
      end else if (start_i) begin
        phase_q   <= PH_RX;
        bit_cnt_q <= '0;
        is_addr_q <= 1'b1;
        rw_q      <= 1'b0;
        oe_q      <= 1'b0;
        wcnt_q    <= '0;
        sel_q     <= '0;
      end else begin
        unique case (phase_q)
          PH_RX: begin
            if (scl_rise_i && bit_cnt_q != 4'd8) begin
              sh_q      <= {sh_q[6:0], rx_bit_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              if (is_addr_q) begin
                if (sh_q[7:1] == SLAVE_ADDR) begin
                  rw_q    <= sh_q[0];
                  oe_q    <= 1'b1;
                  phase_q <= PH_ACK;
                end else begin
                  phase_q <= PH_IDLE;
                end
              end else begin
                oe_q    <= 1'b1;
                phase_q <= PH_ACK;
                if (data_slot) begin
                  wr_en_q   <= 1'b1;
                  wr_idx_q  <= IDX_W'(wcnt_q - WCNT_W'(HDR_BYTES));
                  wr_data_q <= sh_q;
                end
                if (wcnt_q != WCNT_W'(WCNT_MAX)) wcnt_q <= wcnt_q + WCNT_W'(1);
              end
            end
          end
          PH_ACK: begin
            if (scl_fall_i) begin
              is_addr_q <= 1'b0;
              bit_cnt_q <= '0;
              if (rw_q) begin
                phase_q <= PH_TX;
                sh_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
              end else begin
                phase_q <= PH_RX;
                oe_q    <= 1'b0;
              end
            end
          end
          PH_TX: begin
            if (scl_fall_i) begin
              if (bit_cnt_q == 4'd7) begin
                oe_q    <= 1'b0;
                phase_q <= PH_MACK;
              end else begin
                sh_q      <= {sh_q[6:0], 1'b0};
                oe_q      <= ~sh_q[6];
                bit_cnt_q <= bit_cnt_q + 4'd1;
              end
            end
          end
          PH_MACK: begin
            if (scl_rise_i) begin
              nack_q <= rx_bit_i;
              // advance early so the next byte is ready at the falling edge
              if (!rx_bit_i && sel_q != SEL_W'(SEL_MAX)) sel_q <= sel_q + SEL_W'(1);
            end else if (scl_fall_i) begin
              bit_cnt_q <= '0;
              if (nack_q) begin
                phase_q <= PH_IDLE;
              end else begin
                phase_q <= PH_TX;
                sh_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
  assign rd_sel_o  = sel_q;
endmodule

// File: rtl/cfg_i2c_blkslave.sv
module cfg_i2c_blkslave #(
  parameter int unsigned NUM_REGS    = 6,
  parameter logic [6:0]  SLAVE_ADDR  = 7'h69,
  parameter int unsigned STRAP_W     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W = $clog2(NUM_REGS),
  localparam int unsigned SEL_W = $clog2(NUM_REGS + 2),
  localparam logic [NUM_REGS*8-1:0] RST_VAL = {{(NUM_REGS-1){8'hFF}}, 8'h00}
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [STRAP_W-1:0]    strap_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0] wr_data, rd_data;
  logic [SEL_W-1:0] rd_sel;

  cfg_i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  cfg_i2c_proto #(.NUM_REGS(NUM_REGS), .SLAVE_ADDR(SLAVE_ADDR), .HDR_BYTES(2)) u_proto (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_bit_i   (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .rd_sel_o   (rd_sel)
  );

  cfg_i2c_regfile #(
    .NUM_REGS (NUM_REGS),
    .STRAP_W  (STRAP_W),
    .STRAP_REG(4),
    .STRAP_LSB(4),
    .RST_VAL  (RST_VAL)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(wr_data),
    .rd_sel_i (rd_sel),
    .strap_i  (strap_i),
    .rd_data_o(rd_data),
    .regs_o   (regs_o)
  );
endmodule

// File: rtl/cfg_i2c_blkslave_chk.sv
module cfg_i2c_blkslave_chk #(
  parameter int unsigned NUM_REGS = 6,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_lvl,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  sda_oe_o,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [NUM_REGS*8-1:0] regs_o
);
  p_stop_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  p_drive_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det)));

  p_regs_on_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_o != $past(regs_o)) |-> $past(wr_en));

  p_write_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));
endmodule

bind cfg_i2c_blkslave cfg_i2c_blkslave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_lvl  (scl_s),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe_o (sda_oe_o),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .regs_o   (regs_o)
);

// File: tb/cfg_i2c_blkslave_test.sv
module cfg_i2c_blkslave_test;
  localparam int Q = 10;
  // [63:60] data byte count, [59:56] strap, [55:0] data, byte j at [55-8j -: 8]
  localparam logic [63:0] VEC [4] = '{
    {4'd6, 4'h0, 56'h11_22_33_44_55_66_00},
    {4'd2, 4'hF, 56'hA5_5A_00_00_00_00_00},
    {4'd7, 4'h5, 56'h01_02_03_04_05_06_07},
    {4'd0, 4'hA, 56'hDE_AD_BE_EF_00_00_00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [3:0] strap = 4'h0;
  logic sda_oe;
  logic [47:0] regs;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] mdl [6];
  logic [7:0] rbuf [10];

  always #5 clk = ~clk;

  cfg_i2c_blkslave uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .sda_oe_o(sda_oe),
    .strap_i (strap),
    .regs_o  (regs)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic v, output logic s);
    sda_m = v; qw();
    scl_m = 1'b1; qw();
    s = sda_bus; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b1; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackbit);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, ackbit);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(nack, s);
  endtask

  function automatic logic [7:0] view(input int k);
    return (k == 4) ? {~strap, mdl[4][3:0]} : mdl[k];
  endfunction

  function automatic logic [47:0] packed_mdl();
    logic [47:0] p;
    for (int k = 0; k < 6; k++) p[k*8 +: 8] = mdl[k];
    return p;
  endfunction

  task automatic do_write(input logic [7:0] addr, input int n, input logic [55:0] d, input bit addressed);
    logic a;
    bus_start();
    send_byte(addr, a);
    chk(a == !addressed, "R1 write address ack", 64'(a), 64'(!addressed));
    send_byte(8'h3C, a);
    if (addressed) chk(a == 1'b0, "R2 command byte ack", 64'(a), 64'd0);
    send_byte(8'h07, a);
    if (addressed) chk(a == 1'b0, "R2 count byte ack", 64'(a), 64'd0);
    for (int j = 0; j < n; j++) begin
      send_byte(d[55-8*j -: 8], a);
      if (addressed) chk(a == 1'b0, "R4 data byte ack", 64'(a), 64'd0);
      if (addressed && j < 6) mdl[j] = d[55-8*j -: 8];
    end
    bus_stop();
  endtask

  // reads count plus k bytes, NACK on the last one
  task automatic do_read(input int k);
    logic a;
    bus_start();
    send_byte(8'hD3, a);
    chk(a == 1'b0, "R1 read address ack", 64'(a), 64'd0);
    recv_byte(k == 0, rbuf[0]);
    for (int j = 1; j <= k; j++) recv_byte(j == k, rbuf[j]);
    bus_stop();
  endtask

  task automatic check_full_read(input string tag);
    do_read(6);
    chk(rbuf[0] == 8'h06, "R5 count byte", 64'(rbuf[0]), 64'h06);
    for (int k = 0; k < 6; k++)
      chk(rbuf[k+1] == view(k), {tag, " read-back byte"}, 64'(rbuf[k+1]), 64'(view(k)));
  endtask

  initial begin
    for (int k = 0; k < 6; k++) mdl[k] = (k == 0) ? 8'h00 : 8'hFF;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R6 sda released in reset", 64'(sda_oe), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R6 reset defaults
    chk(regs == 48'hFFFF_FFFF_FF00, "R6 reset registers", 64'(regs), 64'hFFFF_FFFF_FF00);
    strap = 4'h3;
    check_full_read("R7 R6");

    // table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < 4; v++) begin
      strap = VEC[v][59:56];
      do_write(8'hD2, int'(VEC[v][63:60]), VEC[v][55:0], 1'b1);
      chk(regs == packed_mdl(), "R3 stored registers", 64'(regs), 64'(packed_mdl()));
      check_full_read("R7 R5");
    end

    // R7: live strap change without a write
    strap = 4'h9;
    do_read(5);
    chk(rbuf[5] == {4'h6, mdl[4][3:0]}, "R7 live strap", 64'(rbuf[5]), 64'({4'h6, mdl[4][3:0]}));
    chk(regs[39:32] == mdl[4], "R7 stored bits on bus", 64'(regs[39:32]), 64'(mdl[4]));

    // R1: foreign addresses ignored
    do_write(8'hA0, 3, 56'h77_88_99_00_00_00_00, 1'b0);
    do_write(8'hD0, 3, 56'h77_88_99_00_00_00_00, 1'b0);
    chk(regs == packed_mdl(), "R1 foreign address leaves registers", 64'(regs), 64'(packed_mdl()));

    // R8: early NACK, then normal read; over-read returns 0xFF
    do_read(2);
    chk(rbuf[2] == view(1), "R8 early nack byte", 64'(rbuf[2]), 64'(view(1)));
    chk(sda_oe == 1'b0, "R8 released after nack", 64'(sda_oe), 64'd0);
    do_read(8);
    chk(rbuf[6] == view(5), "R8 last register", 64'(rbuf[6]), 64'(view(5)));
    chk(rbuf[7] == 8'hFF, "R8 over-read byte", 64'(rbuf[7]), 64'hFF);
    chk(rbuf[8] == 8'hFF, "R8 over-read byte", 64'(rbuf[8]), 64'hFF);
    chk(sda_oe == 1'b0, "R9 released after stop", 64'(sda_oe), 64'd0);

    // R3: partial write after readback keeps upper registers
    do_write(8'hD2, 1, 56'h5C_00_00_00_00_00_00, 1'b1);
    chk(regs == packed_mdl(), "R3 single byte write", 64'(regs), 64'(packed_mdl()));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule